// File: doc/BRIEF.md
# Two-Lane Serial Flash Read Engine

This block is a serial-flash master for read traffic only. A requester hands it a start address, a byte count and a read kind. The engine lowers chip select and runs the serial clock. On the MOSI line it sends the command byte, the 24-bit address and eight idle clocks, most significant bit first. It then gathers the returned bytes and presents them in address order on a valid/ready output stream. Two read kinds exist. The single-lane kind takes one bit per clock from MISO. The two-lane kind releases the MOSI driver once the idle clocks are over and takes two bits per clock, one from MISO and one from MOSI. A third kind reads the device identification bytes. It sends a bare command byte with no address and no idle clocks.

Two configuration inputs permit the fast single-lane kind and the two-lane kind. The two-lane kind is allowed only when both are set. A request that the configuration does not allow is refused with a one-cycle error pulse and causes no bus activity. The serial clock idles low. The engine changes MOSI on falling serial edges and samples on rising edges. Each half period lasts `cfg_div`+1 system clocks. When the output stream is not accepted, the serial clock simply waits.

Top module: `sfr_dual_reader`

## Requirements
- R1: A read sends a command byte, then address bits 23 down to 0, then 8 idle clocks, all on MOSI, one bit per rising serial edge, MSB first: 40 rising edges in all. The command byte is 0x0B for the single-lane kind and 0x3B for the two-lane kind.
- R2: In a two-lane read, `spi_mosi_oe` falls after the 40th rising edge and stays low until chip select rises. Each later rising edge captures one bit pair, MISO as the odd bit and MOSI as the even bit, in the order (7,6), (5,4), (3,2), (1,0). One byte therefore takes 4 rising edges.
- R3: In a single-lane read, each rising edge after the 40th captures one bit from MISO, MSB first, so one byte takes 8 rising edges.
- R4: An identification read sends command 0x9F in 8 rising edges. The single-lane data bytes follow directly, with no address and no idle clocks.
- R5: `req_kind` encodes 0 = single-lane fast, 1 = two-lane, 2 = identification, 3 = reserved. Kind 0 needs `cfg_fast_en`. Kind 1 needs both `cfg_fast_en` and `cfg_dual_en`. Kind 3 is never allowed. A refused request gives `req_err` high in the cycle after acceptance, and chip select stays high.
- R6: An allowed request with `req_len` = 0 gives `done` high in the cycle after acceptance. There is no chip select or clock activity.
- R7: Exactly `req_len` bytes are delivered, in rising address order from the start address, within one command.
- R8: While a byte waits unaccepted on the output, the data is stable, no further data rising edge occurs, and no byte is lost.
- R9: The serial clock is low whenever chip select is high. Chip select stays high for at least 4·(`cfg_div`+1) system cycles between two commands.
- R10: Outside stalls, each serial half period, including the one from the fall of chip select to the first rising edge, lasts `cfg_div`+1 system cycles.
- R11: `done` pulses once per command, after chip select has risen and the inter-command gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fast_en | input | 1 | Permits fast single-lane reads |
| cfg_dual_en | input | 1 | Permits two-lane reads (with cfg_fast_en) |
| cfg_div | input | DIV_W | Half period of serial clock minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken |
| req_kind | input | 2 | Read kind (see R5) |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes |
| req_err | output | 1 | Request refused (pulse) |
| done | output | 1 | Command finished (pulse) |
| rsp_valid | output | 1 | Data byte offered |
| rsp_ready | input | 1 | Data byte taken |
| rsp_data | output | 8 | Data byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | MOSI output value |
| spi_mosi_oe | output | 1 | MOSI output enable |
| spi_mosi_i | input | 1 | MOSI pad value read back |
| spi_miso | input | 1 | MISO input |

## Verification
The clash of interest is a completed byte meeting the next rising serial edge. In a two-lane read a byte is finished every 4 rising edges. With the output not yet taken, the same cycle would have to both hold the waiting byte and capture the next bit pair. The bench provokes this by accepting output only one cycle in seven during a two-lane read, so that almost every byte boundary stalls. It judges the outcome by comparing every delivered byte, in order, with the flash model's contents. A second clash is a new request that arrives while a command is still ending. It is judged by measuring the chip-select high time against the required gap.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int ADDR_W   = 24;
    localparam int CMD_W    = 8;
    localparam int IDLE_W   = 8;
    localparam int SEQ_W    = CMD_W + ADDR_W + IDLE_W;
    localparam int ECNT_W   = $clog2(SEQ_W + 1);

    localparam logic [7:0] OPC_FAST  = 8'h0B;
    localparam logic [7:0] OPC_TWO   = 8'h3B;
    localparam logic [7:0] OPC_IDENT = 8'h9F;

    typedef enum logic [1:0] {
        RK_FAST  = 2'd0,
        RK_TWO   = 2'd1,
        RK_IDENT = 2'd2,
        RK_RSVD  = 2'd3
    } rk_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_TAIL,
        PH_GAP
    } ph_t;

    typedef struct packed {
        rk_t               kind;
        logic              two_lane;
        logic [ECNT_W-1:0] lead_bits;
    } job_t;

    function automatic logic [7:0] op_code(rk_t k);
        case (k)
            RK_FAST:  return OPC_FAST;
            RK_TWO:   return OPC_TWO;
            default:  return OPC_IDENT;
        endcase
    endfunction

    function automatic logic [ECNT_W-1:0] lead_len(rk_t k);
        return (k == RK_IDENT) ? ECNT_W'(CMD_W) : ECNT_W'(SEQ_W);
    endfunction

    function automatic logic kind_allowed(rk_t k, logic fast_en, logic dual_en);
        case (k)
            RK_FAST:  return fast_en;
            RK_TWO:   return fast_en & dual_en;
            RK_IDENT: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sfr_tick.sv
module sfr_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt >= div);
    assign tick   = run && at_end && !hold;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!at_end) begin
            cnt <= cnt + DIV_W'(1);
        end else if (!hold) begin
            cnt <= '0;
        end
    end

    // a held tick stays pending until released
    assert_tick_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (run && at_end && hold) |=> (!run || at_end));

endmodule

// File: rtl/sfr_gather.sv
module sfr_gather (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample,
    input  logic       two_lane,
    input  logic       lane_hi,
    input  logic       lane_lo,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       byte_done
);
    logic [7:0] acc;
    logic [2:0] pcnt;
    logic [7:0] next_acc;
    logic       last_piece;

    assign next_acc   = two_lane ? {acc[5:0], lane_hi, lane_lo} : {acc[6:0], lane_hi};
    assign last_piece = two_lane ? (pcnt == 3'd3) : (pcnt == 3'd7);
    assign byte_done  = sample && last_piece;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            pcnt      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (clear) begin
                acc  <= '0;
                pcnt <= '0;
            end else if (sample) begin
                acc <= next_acc;
                if (last_piece) begin
                    pcnt      <= '0;
                    out_data  <= next_acc;
                    out_valid <= 1'b1;
                end else begin
                    pcnt <= pcnt + 3'd1;
                end
            end
        end
    end

    assert_hold_byte_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // the sequencer must never capture while a byte is still waiting
    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        sample |-> !out_valid);

endmodule

// File: rtl/sfr_dual_reader.sv
module sfr_dual_reader
    import sfr_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int LEN_W     = 16,
    parameter int GAP_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_fast_en,
    input  logic             cfg_dual_en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_err,
    output logic             done,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [7:0]       rsp_data,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi_o,
    output logic             spi_mosi_oe,
    input  logic             spi_mosi_i,
    input  logic             spi_miso
);
    localparam int GC_W = $clog2(GAP_TICKS + 1);

    ph_t               ph;
    job_t              job;
    rk_t               kind_in;
    logic [SEQ_W-1:0]  sh;
    logic [ECNT_W-1:0] ecnt;
    logic [LEN_W-1:0]  rem;
    logic [GC_W-1:0]   gcnt;
    logic              fin;
    logic              sck_q, cs_q, oe_q, err_q, done_q;
    logic              tick, hold, run, rise, fall, in_data, sample, accept, byte_done;

    assign kind_in   = rk_t'(req_kind);
    assign req_ready = (ph == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign run       = (ph != PH_IDLE);
    assign in_data   = (ecnt == job.lead_bits);
    assign hold      = (ph == PH_SHIFT) && !sck_q && in_data && rsp_valid;
    assign rise      = tick && (ph == PH_SHIFT) && !sck_q;
    assign fall      = tick && (ph == PH_SHIFT) && sck_q;
    assign sample    = rise && in_data;

    sfr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .hold (hold),
        .div  (cfg_div),
        .tick (tick)
    );

    sfr_gather u_gather (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .sample    (sample),
        .two_lane  (job.two_lane),
        .lane_hi   (spi_miso),
        .lane_lo   (spi_mosi_i),
        .out_ready (rsp_ready),
        .out_valid (rsp_valid),
        .out_data  (rsp_data),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            job    <= '0;
            sh     <= '0;
            ecnt   <= '0;
            rem    <= '0;
            gcnt   <= '0;
            fin    <= 1'b0;
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            oe_q   <= 1'b1;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        if (!kind_allowed(kind_in, cfg_fast_en, cfg_dual_en)) begin
                            err_q <= 1'b1;
                        end else if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            job.kind      <= kind_in;
                            job.two_lane  <= (kind_in == RK_TWO);
                            job.lead_bits <= lead_len(kind_in);
                            sh   <= {op_code(kind_in),
                                     (kind_in == RK_IDENT) ? 24'h0 : req_addr,
                                     8'h00};
                            ecnt <= '0;
                            rem  <= req_len;
                            fin  <= 1'b0;
                            cs_q <= 1'b0;
                            oe_q <= 1'b1;
                            ph   <= PH_SHIFT;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (rise) begin
                        sck_q <= 1'b1;
                        if (!in_data) begin
                            ecnt <= ecnt + ECNT_W'(1);
                        end
                        if (byte_done) begin
                            rem <= rem - LEN_W'(1);
                            if (rem == LEN_W'(1)) begin
                                fin <= 1'b1;
                            end
                        end
                    end else if (fall) begin
                        sck_q <= 1'b0;
                        if (fin) begin
                            ph <= PH_TAIL;
                        end else if (!in_data) begin
                            sh <= {sh[SEQ_W-2:0], 1'b0};
                        end else if (job.two_lane) begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick) begin
                        cs_q <= 1'b1;
                        oe_q <= 1'b1;
                        sh   <= '0;
                        gcnt <= '0;
                        ph   <= PH_GAP;
                    end
                end
                default: begin
                    if (tick) begin
                        if (gcnt == GC_W'(GAP_TICKS - 1)) begin
                            ph     <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            gcnt <= gcnt + GC_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign spi_cs_n    = cs_q;
    assign spi_sck     = sck_q;
    assign spi_mosi_o  = sh[SEQ_W-1];
    assign spi_mosi_oe = oe_q;
    assign req_err     = err_q;
    assign done        = done_q;

    assert_sck_low_idle_R9: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> spi_cs_n);

    assert_release_two_lane_R2: assert property (@(posedge clk) disable iff (rst)
        !spi_mosi_oe |-> (!spi_cs_n && job.two_lane));

    assert_refuse_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (spi_cs_n && !done));

    assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_len == '0) |=> spi_cs_n);

    assert_stall_clock_R8: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SHIFT && !spi_sck && in_data && rsp_valid) |=> !spi_sck);

    assert_done_after_cs_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (spi_cs_n && req_ready));

endmodule

// File: tb/sim_sfr_dual_reader.sv
module sim_sfr_dual_reader;
    localparam int DIV_W = 8;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             cfg_fast_en = 1'b1, cfg_dual_en = 1'b1;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             req_valid = 1'b0, req_ready, req_err, done;
    logic [1:0]       req_kind = '0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             rsp_valid, rsp_ready = 1'b1;
    logic [7:0]       rsp_data;
    logic             spi_cs_n, spi_sck, spi_mosi_o, spi_mosi_oe, spi_mosi_i, spi_miso;

    sfr_dual_reader #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .cfg_fast_en(cfg_fast_en), .cfg_dual_en(cfg_dual_en),
        .cfg_div(cfg_div), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
        .req_err(req_err), .done(done), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi_o(spi_mosi_o), .spi_mosi_oe(spi_mosi_oe),
        .spi_mosi_i(spi_mosi_i), .spi_miso(spi_miso)
    );

    int errs = 0, checks = 0, cur_div = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    function automatic logic [7:0] mem_at(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5C;
    endfunction

    function automatic logic [7:0] ident_at(int i);
        case (i % 3)
            0:       return 8'hC2;
            1:       return 8'h25;
            default: return 8'h39;
        endcase
    endfunction

    // behavioural flash
    int          rc = 0, contention = 0, fs, fd;
    logic [7:0]  f_op = 0, fb;
    logic [23:0] f_addr = 0;
    logic        f_miso = 0, f_mosi = 0, f_men = 0, sck_d = 0;

    always @(spi_sck or spi_cs_n) begin
        if (spi_cs_n) begin
            rc = 0; f_men = 0; f_miso = 0;
        end else if (spi_sck && !sck_d) begin
            if (f_men && spi_mosi_oe) contention++;
            if (rc < 8) f_op = {f_op[6:0], spi_mosi_o};
            else if (rc < 32) f_addr = {f_addr[22:0], spi_mosi_o};
            rc++;
        end else if (!spi_sck && sck_d) begin
            fs = (f_op == 8'h9F) ? 8 : 40;
            if (rc >= fs) begin
                fd = rc - fs;
                if (f_op == 8'h3B) begin
                    fb = mem_at(f_addr + 24'(fd / 4));
                    f_miso = fb[7 - 2 * (fd % 4)];
                    f_mosi = fb[6 - 2 * (fd % 4)];
                    f_men  = 1'b1;
                end else if (f_op == 8'h9F) begin
                    fb = ident_at(fd / 8);
                    f_miso = fb[7 - (fd % 8)];
                end else begin
                    fb = mem_at(f_addr + 24'(fd / 8));
                    f_miso = fb[7 - (fd % 8)];
                end
            end
        end
        sck_d = spi_sck;
    end

    assign spi_miso   = f_miso;
    assign spi_mosi_i = f_men ? f_mosi : spi_mosi_o;

    // output collection and back-pressure
    logic [7:0] got [0:63];
    int         got_n = 0, bp = 0;
    logic       rdy_mode = 1'b0, saw_release = 1'b0;

    always @(posedge clk) begin
        bp <= bp + 1;
        rsp_ready <= rdy_mode ? (bp % 7 == 0) : 1'b1;
    end

    // timing monitors (R9, R10)
    int   hp_cnt = 0, hp_bad = 0, gap_cnt = 0, gap_bad = 0;
    logic gap_prior = 0, cs_m = 1, sck_m = 0;

    always @(negedge clk) begin
        if (rsp_valid && rsp_ready) begin
            if (got_n < 64) got[got_n] = rsp_data;
            got_n++;
        end
        if (!spi_cs_n && !spi_mosi_oe) saw_release = 1'b1;
        hp_cnt++;
        gap_cnt++;
        if (cs_m && !spi_cs_n) begin
            if (gap_prior && gap_cnt < 4 * (cur_div + 1)) gap_bad++;
            hp_cnt = 0;
        end
        if (!cs_m && spi_cs_n) begin
            gap_prior = 1'b1;
            gap_cnt = 0;
        end
        if (!spi_cs_n && spi_sck != sck_m) begin
            if (rc <= 8 && hp_cnt != cur_div + 1) hp_bad++;
            hp_cnt = 0;
        end
        cs_m = spi_cs_n;
        sck_m = spi_sck;
    end

    task automatic issue(logic [1:0] k, logic [23:0] a, int n);
        @(negedge clk);
        req_kind = k; req_addr = a; req_len = LEN_W'(n); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_cmd;
        while (!done) @(negedge clk);
        chk(spi_cs_n, "R11", "cs high at done", spi_cs_n, 1);
        while (rsp_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(logic [1:0] k, logic [23:0] a, int n, int div, bit slow);
        cfg_div = DIV_W'(div); cur_div = div; rdy_mode = slow;
        got_n = 0; contention = 0; saw_release = 0;
        issue(k, a, n);
        finish_cmd();
        case (k)
            2'd0: chk(f_op == 8'h0B, "R1", "single opcode", f_op, 8'h0B);
            2'd1: chk(f_op == 8'h3B, "R1", "two-lane opcode", f_op, 8'h3B);
            default: chk(f_op == 8'h9F, "R4", "ident opcode", f_op, 8'h9F);
        endcase
        if (k != 2'd2) chk(f_addr == a, "R1", "address", f_addr, a);
        chk(got_n == n, "R7", "byte count", got_n, n);
        for (int i = 0; i < n && i < got_n; i++) begin
            if (k == 2'd2) chk(got[i] == ident_at(i), "R4", "ident byte", got[i], ident_at(i));
            else chk(got[i] == mem_at(a + 24'(i)), k == 2'd1 ? "R2" : "R3", "data byte",
                     got[i], mem_at(a + 24'(i)));
        end
        chk(contention == 0, "R2", "MOSI contention", contention, 0);
        if (k == 2'd1) chk(saw_release, "R2", "MOSI released", saw_release, 1);
        else chk(!saw_release, "R2", "MOSI kept driven", saw_release, 0);
        rdy_mode = 1'b0;
    endtask

    task automatic t_reset;
        chk(spi_cs_n, "R9", "reset cs_n", spi_cs_n, 1);
        chk(!spi_sck, "R9", "reset sck", spi_sck, 0);
        chk(!rsp_valid, "R8", "reset rsp_valid", rsp_valid, 0);
        chk(req_ready, "R5", "reset req_ready", req_ready, 1);
    endtask

    task automatic t_refuse(logic fe, logic de, logic [1:0] k);
        int cs_low = 0;
        cfg_fast_en = fe; cfg_dual_en = de;
        issue(k, 24'h000100, 4);
        chk(req_err, "R5", "error pulse", req_err, 1);
        repeat (30) begin
            @(negedge clk);
            if (!spi_cs_n) cs_low++;
        end
        chk(cs_low == 0, "R5", "no bus activity", cs_low, 0);
        cfg_fast_en = 1'b1; cfg_dual_en = 1'b1;
    endtask

    task automatic t_zero;
        int cs_low = 0;
        got_n = 0;
        issue(2'd1, 24'h000200, 0);
        chk(done, "R6", "immediate done", done, 1);
        chk(!req_err, "R6", "no error", req_err, 0);
        repeat (30) begin
            @(negedge clk);
            if (!spi_cs_n) cs_low++;
        end
        chk(cs_low == 0 && got_n == 0, "R6", "no activity", cs_low + got_n, 0);
    endtask

    task automatic t_back_to_back;
        cfg_div = DIV_W'(1); cur_div = 1; got_n = 0;
        issue(2'd1, 24'h00AB00, 2);
        issue(2'd0, 24'h00CD10, 2);
        finish_cmd();
        chk(got_n == 4, "R7", "b2b count", got_n, 4);
        chk(got[0] == mem_at(24'h00AB00) && got[1] == mem_at(24'h00AB01), "R7",
            "first command bytes", {got[0], got[1]}, {mem_at(24'h00AB00), mem_at(24'h00AB01)});
        chk(got[2] == mem_at(24'h00CD10) && got[3] == mem_at(24'h00CD11), "R7",
            "second command bytes", {got[2], got[3]}, {mem_at(24'h00CD10), mem_at(24'h00CD11)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        do_read(2'd1, 24'h123456, 6, 1, 1'b0);   // R1 R2 R7
        do_read(2'd0, 24'hFFFFFE, 4, 2, 1'b0);   // R1 R3 R7
        do_read(2'd2, 24'h0, 3, 0, 1'b0);        // R4
        do_read(2'd1, 24'h004000, 9, 1, 1'b1);   // R8 two-lane stall
        do_read(2'd0, 24'h000777, 3, 0, 1'b1);   // R8 single-lane stall
        t_refuse(1'b0, 1'b1, 2'd1);              // R5
        t_refuse(1'b1, 1'b0, 2'd1);              // R5
        t_refuse(1'b0, 1'b0, 2'd0);              // R5
        t_refuse(1'b1, 1'b1, 2'd3);              // R5
        t_zero();                                // R6
        t_back_to_back();                        // R9 R7
        chk(hp_bad == 0, "R10", "half-period violations", hp_bad, 0);
        chk(gap_bad == 0, "R9", "chip-select gap violations", gap_bad, 0);
        summary();
        $finish;
    end

endmodule